// File: doc/BRIEF.md
# PCI Interrupt Router

This block collects the level-sensitive INTx requests of the PCI devices that sit in a small set of slots. It folds them onto four shared PCI interrupt lines, called PIRQA to PIRQD here. It then steers each of those lines onto one input of a sixteen-input legacy interrupt controller. Each slot's pins are rotated by the slot number before they are merged. Because of this rotation, the INTA pins of neighbouring slots land on different PIRQ lines, which spreads the load across them.

A byte-wide configuration port holds four routing registers, one per PIRQ line. Each register either names the legacy IRQ that its line drives or switches the line off. The output is a 16-bit level vector. It is formed combinationally from the current pin levels and the current routing registers. The controller sees the wired-OR of every PIRQ line that points at a given IRQ.

A build-time parameter selects between two reset behaviours. In one, a fixed default routing is live from reset. In the other, every line is off until software programs it.

Top module: `pirq_router`

## Requirements
- R1: Pin p of slot s drives PIRQ line (p + s - 1) mod 4. Pins are numbered INTA=0 to INTD=3, slots are numbered 1 to 4 on input bit (s-1)*4+p of `dev_int`, and PIRQA=0. A PIRQ line's level is the OR of all pins that rotate onto it.
- R2: The routing registers for PIRQA, PIRQB, PIRQC and PIRQD sit at configuration offsets 0x60, 0x61, 0x62 and 0x63. A write (`cfg_wr` high at a rising clock edge) stores `cfg_wdata`, and the new value is readable from the next cycle. A read of an offset returns the stored byte combinationally.
- R3: A write to any offset outside 0x60 to 0x63 changes no routing register, and a read of any such offset returns 0x00.
- R4: A routing register with bit 7 set disables its PIRQ line: that line drives no IRQ.
- R5: With bit 7 clear, a PIRQ line drives IRQ n only when bits 6:0 equal n and n is below 16. Values 16 to 127 route the line nowhere.
- R6: Each IRQ output is the logical OR of the levels of all enabled PIRQ lines routed to it.
- R7: The IRQ vector follows the pin levels and routing registers with no register stage. In the cycle a route is rewritten, the level leaves the old IRQ and appears on the new one.
- R8: With `FIXED_ROUTE`=1, reset loads 0x0A, 0x0A, 0x0B, 0x0B into the PIRQA to PIRQD registers, so PIRQA and PIRQB drive IRQ 10 and PIRQC and PIRQD drive IRQ 11.
- R9: With `FIXED_ROUTE`=0, reset loads 0x80 into every routing register, so no IRQ is driven until software writes one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dev_int | input | 16 | Synchronized device INTx levels, 4 slots by 4 pins |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| irq_lvl | output | 16 | Level vector toward the legacy interrupt controller |

## Verification
A sweep of single active pins across all sixteen slot and pin positions is run with four distinct routes programmed. This sweep shows whether the rotation picks the right PIRQ line, since each line lands on its own IRQ. Directed routes with bit 7 set, and with values of 16, 127 and 15, separate the disable bit from the range limit. Two lines sharing IRQ 15, with one of them then dropped, exercise the wired-OR. A rewrite under an active level shows whether the old IRQ drops in the same cycle. Seeded random pin vectors mixed with random route writes, drawn from valid, disabled and out-of-range values, are compared against a bench model. A second instance built with the other reset variant checks that every line starts off.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  // Number of shared PCI interrupt lines and their routing registers
  localparam int unsigned PIRQ_COUNT = 4;
  // Configuration offset of the first routing register
  localparam logic [7:0] ROUTE_BASE = 8'h60;
  // Routing register value that disables a line
  localparam logic [7:0] ROUTE_OFF = 8'h80;
  // Default IRQ numbers for the fixed reset variant
  localparam logic [7:0] ROUTE_LOW_DEF  = 8'h0A;
  localparam logic [7:0] ROUTE_HIGH_DEF = 8'h0B;

  typedef logic [7:0] route_t;
endpackage

// File: rtl/pirq_slot_swizzle.sv
module pirq_slot_swizzle #(
  parameter int unsigned N_SLOT    = 4,
  parameter int unsigned N_PIN     = 4,
  parameter int unsigned N_PIRQ    = 4,
  parameter int unsigned BASE_SLOT = 1
) (
  input  logic [N_SLOT*N_PIN-1:0] dev_int,
  output logic [N_PIRQ-1:0]       pirq_lvl
);
  // Each slot's pins are rotated by the slot number, then OR-merged per line
  always_comb begin
    pirq_lvl = '0;
    for (int s = 0; s < int'(N_SLOT); s++) begin
      for (int p = 0; p < int'(N_PIN); p++) begin
        pirq_lvl[(p + s + int'(BASE_SLOT) + int'(N_PIRQ) - 1) % int'(N_PIRQ)] |=
          dev_int[s*int'(N_PIN) + p];
      end
    end
  end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
#(
  parameter int unsigned N_PIRQ      = PIRQ_COUNT,
  parameter bit          FIXED_ROUTE = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [7:0]             cfg_addr,
  input  logic [7:0]             cfg_wdata,
  output logic [7:0]             cfg_rdata,
  output logic [N_PIRQ-1:0][7:0] route_q
);
  logic [N_PIRQ-1:0][7:0] route_d;
  logic [N_PIRQ-1:0]      wr_en;

  for (genvar i = 0; i < N_PIRQ; i++) begin : g_reg
    localparam logic [7:0] OFS = ROUTE_BASE + 8'(i);
    localparam route_t RST_VAL = FIXED_ROUTE ?
      ((i < N_PIRQ/2) ? ROUTE_LOW_DEF : ROUTE_HIGH_DEF) : ROUTE_OFF;

    // Clock enable per register
    assign wr_en[i] = cfg_wr && (cfg_addr == OFS);

    always_comb begin
      route_d[i] = route_q[i];
      if (wr_en[i]) route_d[i] = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) route_q[i] <= RST_VAL;
      else        route_q[i] <= route_d[i];
    end

    // R2
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == OFS) |=> route_q[i] == $past(cfg_wdata));
    // R3
    no_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && cfg_addr == OFS) |=> $stable(route_q[i]));
  end

  always_comb begin
    cfg_rdata = 8'h00;
    for (int i = 0; i < int'(N_PIRQ); i++) begin
      if (cfg_addr == ROUTE_BASE + 8'(i)) cfg_rdata = route_q[i];
    end
  end
endmodule

// File: rtl/pirq_level_merge.sv
module pirq_level_merge #(
  parameter int unsigned N_PIRQ = 4,
  parameter int unsigned N_IRQ  = 16
) (
  input  logic [N_PIRQ-1:0][7:0] route_q,
  input  logic [N_PIRQ-1:0]      pirq_lvl,
  output logic [N_IRQ-1:0]       irq_lvl
);
  logic [N_PIRQ-1:0] line_on;

  always_comb begin
    for (int p = 0; p < int'(N_PIRQ); p++) begin
      line_on[p] = !route_q[p][7] && pirq_lvl[p];
    end
  end

  // Wired-OR of every enabled line aimed at each IRQ; only numbers below N_IRQ match
  always_comb begin
    irq_lvl = '0;
    for (int k = 0; k < int'(N_IRQ); k++) begin
      for (int p = 0; p < int'(N_PIRQ); p++) begin
        if (line_on[p] && (route_q[p][6:0] == 7'(k))) irq_lvl[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int unsigned N_SLOT      = 4,
  parameter int unsigned N_PIN       = 4,
  parameter int unsigned N_IRQ       = 16,
  parameter int unsigned BASE_SLOT   = 1,
  parameter bit          FIXED_ROUTE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SLOT*N_PIN-1:0] dev_int,
  input  logic                    cfg_wr,
  input  logic [7:0]              cfg_addr,
  input  logic [7:0]              cfg_wdata,
  output logic [7:0]              cfg_rdata,
  output logic [N_IRQ-1:0]        irq_lvl
);
  localparam int unsigned N_PIRQ = PIRQ_COUNT;

  // Asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [N_PIRQ-1:0]      pirq_lvl;
  logic [N_PIRQ-1:0][7:0] route_q;

  pirq_slot_swizzle #(
    .N_SLOT(N_SLOT), .N_PIN(N_PIN), .N_PIRQ(N_PIRQ), .BASE_SLOT(BASE_SLOT)
  ) u_swizzle (
    .dev_int (dev_int),
    .pirq_lvl(pirq_lvl)
  );

  pirq_route_regs #(
    .N_PIRQ(N_PIRQ), .FIXED_ROUTE(FIXED_ROUTE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .route_q  (route_q)
  );

  pirq_level_merge #(
    .N_PIRQ(N_PIRQ), .N_IRQ(N_IRQ)
  ) u_merge (
    .route_q (route_q),
    .pirq_lvl(pirq_lvl),
    .irq_lvl (irq_lvl)
  );

  // R1
  pirq_fanin_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(pirq_lvl) <= $countones(dev_int));
  // R4
  all_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (route_q[0][7] && route_q[1][7] && route_q[2][7] && route_q[3][7]) |-> irq_lvl == '0);
  // R6
  irq_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_lvl != '0) |-> (pirq_lvl != '0));
  // R3
  rd_outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_addr < ROUTE_BASE || cfg_addr > ROUTE_BASE + 8'(N_PIRQ - 1)) |-> cfg_rdata == 8'h00);
endmodule

// File: tb/test_pirq_router.sv
module test_pirq_router;
  logic        clk;
  logic        rst_n;
  logic [15:0] dev_int;
  logic        cfg_wr;
  logic [7:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata, alt_rdata;
  logic [15:0] irq_lvl, alt_irq;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] sh [4];

  pirq_router i_pirq_router (
    .clk(clk), .rst_n(rst_n), .dev_int(dev_int), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_lvl(irq_lvl)
  );

  pirq_router #(.FIXED_ROUTE(1'b0)) i_pirq_router_alt (
    .clk(clk), .rst_n(rst_n), .dev_int(dev_int), .cfg_wr(1'b0),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(alt_rdata), .irq_lvl(alt_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [3:0] f_pirq(logic [15:0] d);
    logic [3:0] r = '0;
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 4; p++)
        r[(p + s) % 4] |= d[s*4 + p];
    return r;
  endfunction

  function automatic logic [15:0] f_irq(logic [15:0] d);
    logic [15:0] e = '0;
    logic [3:0]  pl = f_pirq(d);
    for (int p = 0; p < 4; p++)
      if (!sh[p][7] && sh[p][6:0] < 7'd16 && pl[p]) e[sh[p][3:0]] = 1'b1;
    return e;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (a >= 8'h60 && a <= 8'h63) sh[a - 8'h60] = d;
    #1;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    cfg_addr = a; #1;
    chk(req, {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  task automatic drive_chk(string req, logic [15:0] d);
    dev_int = d; #1;
    chk(req, {16'h0, irq_lvl}, {16'h0, f_irq(d)});
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    rst_n = 1'b0; dev_int = '0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    sh[0] = 8'h0A; sh[1] = 8'h0A; sh[2] = 8'h0B; sh[3] = 8'h0B;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 reset values of the fixed variant
    for (int i = 0; i < 4; i++) rd_chk("R8", 8'h60 + 8'(i), sh[i]);
    drive_chk("R8", 16'h0000);
    drive_chk("R8", 16'h0001);            // slot1 INTA -> PIRQA -> IRQ10
    chk("R8", {16'h0, irq_lvl}, 32'h0000_0400);
    drive_chk("R8", 16'h0004);            // slot1 INTC -> PIRQC -> IRQ11
    chk("R8", {16'h0, irq_lvl}, 32'h0000_0800);
    // R9 the other variant starts with every line off
    for (int i = 0; i < 4; i++) begin
      cfg_addr = 8'h60 + 8'(i); #1;
      chk("R9", {24'h0, alt_rdata}, 32'h80);
    end
    dev_int = 16'hFFFF; #1;
    chk("R9", {16'h0, alt_irq}, 32'h0);

    // R2 distinct routes then readback
    wr(8'h60, 8'h03); wr(8'h61, 8'h05); wr(8'h62, 8'h07); wr(8'h63, 8'h09);
    rd_chk("R2", 8'h60, 8'h03); rd_chk("R2", 8'h61, 8'h05);
    rd_chk("R2", 8'h62, 8'h07); rd_chk("R2", 8'h63, 8'h09);

    // R1 single-pin sweep over every slot and pin
    for (int b = 0; b < 16; b++) drive_chk("R1", 16'(1) << b);
    // slot2 INTA -> PIRQB -> IRQ5
    dev_int = 16'h0010; #1;
    chk("R1", {16'h0, irq_lvl}, 32'h0000_0020);

    // R4 disable bit
    wr(8'h60, 8'h83);
    drive_chk("R4", 16'h0001);
    chk("R4", {16'h0, irq_lvl}, 32'h0);
    // R5 out of range and top valid number
    wr(8'h60, 8'h10);  drive_chk("R5", 16'h0001);
    chk("R5", {16'h0, irq_lvl}, 32'h0);
    wr(8'h60, 8'h7F);  drive_chk("R5", 16'h0001);
    wr(8'h60, 8'h0F);  drive_chk("R5", 16'h0001);
    chk("R5", {16'h0, irq_lvl}, 32'h0000_8000);

    // R6 two lines sharing IRQ15
    wr(8'h61, 8'h0F);
    drive_chk("R6", 16'h0003);            // PIRQA and PIRQB
    drive_chk("R6", 16'h0002);            // only PIRQB
    chk("R6", {16'h0, irq_lvl}, 32'h0000_8000);
    drive_chk("R6", 16'h0000);

    // R7 reroute under an active level: old IRQ drops in the same cycle
    wr(8'h61, 8'h05);
    dev_int = 16'h0001;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'h60; cfg_wdata = 8'h04;
    #1 chk("R7", {16'h0, irq_lvl}, 32'h0000_8000);
    @(posedge clk); #1;
    cfg_wr = 1'b0; sh[0] = 8'h04;
    chk("R7", {16'h0, irq_lvl}, 32'h0000_0010);

    // R3 writes outside the window have no effect, reads there give zero
    wr(8'h5F, 8'h55); wr(8'h64, 8'h55); wr(8'hE0, 8'h55);
    for (int i = 0; i < 4; i++) rd_chk("R3", 8'h60 + 8'(i), sh[i]);
    rd_chk("R3", 8'h64, 8'h00);
    rd_chk("R3", 8'h5F, 8'h00);
    drive_chk("R3", 16'hFFFF);

    // Random mix
    void'($urandom(32'd20240611));
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 3) == 0) begin
        case ($urandom_range(0, 2))
          0: rv = 8'($urandom_range(0, 15));
          1: rv = 8'h80 | 8'($urandom_range(0, 127));
          default: rv = 8'($urandom_range(16, 127));
        endcase
        wr(8'h60 + 8'($urandom_range(0, 3)), rv);
      end
      @(negedge clk);
      drive_chk("R6", 16'($urandom));
    end
    for (int i = 0; i < 4; i++) rd_chk("R2", 8'h60 + 8'(i), sh[i]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule